// File: doc/BRIEF.md
# RGB LED Matrix Scan Driver

This block refreshes a 64 x 64 RGB LED panel that is split into an upper and a lower half. Both halves share one shift clock, one latch strobe, one active-low output enable and a 5-bit row address. Six colour lines carry one pixel of each half per shift clock. Each address selects row n of the upper half and row n+32 of the lower half together, so 32 row-loads cover the panel for one bitplane.

Brightness comes from binary-weighted bitplanes. For every row address the block shifts plane 0 up to plane D-1 in turn. After each row-load it blanks the panel, presents the row address, pulses the latch and lights the panel for a time proportional to 2^plane. The next row-load shifts in while the current one is lit. The colour depth D (1..8) is a run-time input and is taken up only at frame boundaries.

Pixels come from an external frame buffer through a fixed-latency read port: a request made in one cycle is answered in the next. The port has no back-pressure, so the buffer must answer every request. Each row-load takes 4*64+3 = 259 system cycles when the lit time of the plane fits inside the shift time. At depth 8 a frame is 66,304 cycles, which gives 1 kHz refresh from a clock of about 66.3 MHz (shift clock of about 16.6 MHz). At depth 1 a clock of 8.3 MHz is enough.

Top module: `led_matrix_scan`

## Requirements
- R1: Each row-load produces exactly 64 shift-clock rising edges, one every 4 cycles, column 0 first. The colour lines hold their value from the cycle before each rising edge.
- R2: The colour lines are ordered bit5..bit0 = {R1,G1,B1,R2,G2,B2}. The first three bits come from the upper half (row r), the last three from the lower half (row r+32), at the same column.
- R3: A read address is {half, row, column}, with half 0 = upper and half 1 = lower (12 bits). Data is taken one cycle after the request. Each row-load issues exactly 128 read requests.
- R4: A buffer word is {R[23:16], G[15:8], B[7:0]}. With depth D, plane p shows bit (8-D+p) of each channel, so the top D bits of each channel are used.
- R5: Scan order: planes 0..D-1 of row address 0, then the planes of row 1, and so on up to row 31, then back to row 0. The row lines show the address of the data being latched.
- R6: After the latch for plane p, the output enable is active for exactly 2*2^p cycles (OE_UNIT=2), starting in the cycle after the latch pulse.
- R7: The latch pulse lasts one cycle with the output enable inactive. The row lines change only while the output enable is inactive.
- R8: Shifting of the next row-load starts right after the latch. Its first shift-clock rising edge comes 5 cycles after the latch cycle, while the previous load is being displayed.
- R9: The depth input is sampled once, at the start of each frame. Values 0 count as 1 and values above 8 count as 8. A frame at depth D has exactly 32*D latch pulses.
- R10: During reset, and after it until the first latch pulse, the output enable is inactive and the shift clock and latch are low.
- R11: When the lit time does not exceed the shift time, successive latch pulses are exactly 259 cycles apart. Waiting for the lit time to expire adds no cycle when both end together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| plane_cnt_i | input | 4 | Requested colour depth in bitplanes |
| fb_rd_en_o | output | 1 | Frame-buffer read request |
| fb_rd_addr_o | output | 12 | Read address {half, row, column} |
| fb_rd_data_i | input | 24 | Read data, one cycle after the request |
| pnl_clk_o | output | 1 | Panel shift clock |
| pnl_lat_o | output | 1 | Panel latch strobe |
| pnl_oe_n_o | output | 1 | Panel output enable, active low |
| pnl_row_o | output | 5 | Panel row address |
| pnl_rgb_o | output | 6 | Colour data {R1,G1,B1,R2,G2,B2} |

## Verification
Two events can land in the same cycle: the lit time of plane 7 (256 cycles) ends in the cycle that the last pixel of the next row-load is shifted. Running a frame at depth 8 produces this case 32 times. The bench checks that the enable was active for exactly 256 cycles, and that the following latch still comes exactly 259 cycles after the previous one. A depth change made in the middle of a frame is checked in the same way: the plane order and the latch count per frame must show that the old depth stays in force until the frame ends.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  // Sequencer phases of one row-load
  typedef enum logic [1:0] {
    SCAN_SHIFT = 2'd0,
    SCAN_WAIT  = 2'd1,
    SCAN_BLANK = 2'd2,
    SCAN_LATCH = 2'd3
  } scan_state_e;

  // Bring a requested plane count into the legal range 1..max_planes
  function automatic int clamp_depth(input int req, input int max_planes);
    if (req < 1) return 1;
    if (req > max_planes) return max_planes;
    return req;
  endfunction

endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import led_scan_pkg::*;
#(
  parameter int COLS       = 64,
  parameter int ROWS       = 32,
  parameter int MAX_PLANES = 8,
  parameter int COL_W      = $clog2(COLS),
  parameter int ROW_W      = $clog2(ROWS),
  parameter int PL_W       = $clog2(MAX_PLANES),
  parameter int DEP_W      = $clog2(MAX_PLANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEP_W-1:0]  depth_req_i,
  input  logic              disp_busy_i,
  output scan_state_e       state_o,
  output logic [1:0]        phase_o,
  output logic [COL_W-1:0]  col_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [PL_W-1:0]   plane_o,
  output logic [DEP_W-1:0]  depth_o,
  output logic              load_disp_o,
  output logic [PL_W-1:0]   disp_plane_o,
  output logic [ROW_W-1:0]  pnl_row_o,
  output logic              pnl_lat_o
);

  scan_state_e      state_q;
  logic [1:0]       ph_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [PL_W-1:0]  plane_q;
  logic [DEP_W-1:0] depth_q;
  logic [ROW_W-1:0] pnl_row_q;
  logic             lat_q;

  logic             frame_start;
  logic             last_col;
  logic             last_plane;
  logic             last_row;
  logic [DEP_W-1:0] depth_clamped;

  always_comb begin
    depth_clamped = DEP_W'(clamp_depth(int'(depth_req_i), MAX_PLANES));
    frame_start   = (state_q == SCAN_SHIFT) && (ph_q == 2'd0) && (col_q == '0)
                    && (row_q == '0) && (plane_q == '0);
    last_col      = (col_q == COL_W'(COLS - 1));
    last_plane    = ((DEP_W'(plane_q) + DEP_W'(1)) == depth_q);
    last_row      = (row_q == ROW_W'(ROWS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SCAN_SHIFT;
      ph_q      <= 2'd0;
      col_q     <= '0;
      row_q     <= '0;
      plane_q   <= '0;
      depth_q   <= DEP_W'(MAX_PLANES);
      pnl_row_q <= '0;
      lat_q     <= 1'b0;
    end else begin
      // depth is taken once, in the first cycle of a frame
      if (frame_start) depth_q <= depth_clamped;
      unique case (state_q)
        SCAN_SHIFT: begin
          ph_q <= ph_q + 2'd1;
          if (ph_q == 2'd3) begin
            if (last_col) begin
              col_q   <= '0;
              state_q <= SCAN_WAIT;
            end else begin
              col_q <= col_q + COL_W'(1);
            end
          end
        end
        SCAN_WAIT: begin
          if (!disp_busy_i) begin
            state_q   <= SCAN_BLANK;
            pnl_row_q <= row_q;
          end
        end
        SCAN_BLANK: begin
          state_q <= SCAN_LATCH;
          lat_q   <= 1'b1;
        end
        SCAN_LATCH: begin
          lat_q   <= 1'b0;
          state_q <= SCAN_SHIFT;
          if (last_plane) begin
            plane_q <= '0;
            row_q   <= last_row ? '0 : row_q + ROW_W'(1);
          end else begin
            plane_q <= plane_q + PL_W'(1);
          end
        end
        default: state_q <= SCAN_SHIFT;
      endcase
    end
  end

  assign state_o      = state_q;
  assign phase_o      = ph_q;
  assign col_o        = col_q;
  assign row_o        = row_q;
  assign plane_o      = plane_q;
  assign depth_o      = depth_q;
  assign load_disp_o  = (state_q == SCAN_LATCH);
  assign disp_plane_o = plane_q;
  assign pnl_row_o    = pnl_row_q;
  assign pnl_lat_o    = lat_q;

endmodule

// File: rtl/oe_weight_timer.sv
module oe_weight_timer #(
  parameter int OE_UNIT    = 2,
  parameter int MAX_PLANES = 8,
  parameter int PL_W       = $clog2(MAX_PLANES),
  parameter int TW         = $clog2(OE_UNIT * (2 ** (MAX_PLANES - 1)) + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [PL_W-1:0] plane_i,
  output logic            busy_o,
  output logic            oe_n_o
);

  logic [TW-1:0] cnt_q;
  logic          act_q;
  logic [TW-1:0] weight;

  always_comb weight = TW'(OE_UNIT) << plane_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      act_q <= 1'b1;
      cnt_q <= weight - TW'(1);
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - TW'(1);
    end
  end

  assign busy_o = act_q;
  assign oe_n_o = ~act_q;

endmodule

// File: rtl/pixel_fetch.sv
module pixel_fetch #(
  parameter int CH_W   = 8,
  parameter int COL_W  = 6,
  parameter int ROW_W  = 5,
  parameter int PL_W   = 3,
  parameter int DEP_W  = 4,
  parameter int ADDR_W = 1 + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shifting_i,
  input  logic [1:0]        phase_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [PL_W-1:0]   plane_i,
  input  logic [DEP_W-1:0]  depth_i,
  output logic              fb_rd_en_o,
  output logic [ADDR_W-1:0] fb_rd_addr_o,
  input  logic [3*CH_W-1:0] fb_rd_data_i,
  output logic              pnl_clk_o,
  output logic [5:0]        pnl_rgb_o
);

  localparam int BIT_W = $clog2(CH_W);

  logic [BIT_W-1:0] bit_idx;
  logic [2:0]       pick;
  logic [2:0]       up_q;
  logic [5:0]       rgb_q;
  logic             clk_q;

  // plane p of depth D uses bit CH_W-D+p of each channel
  always_comb bit_idx = BIT_W'(CH_W - int'(depth_i) + int'(plane_i));

  generate
    for (genvar ch = 0; ch < 3; ch++) begin : g_chan
      logic [CH_W-1:0] chan;
      assign chan     = fb_rd_data_i[ch*CH_W +: CH_W];
      assign pick[ch] = chan[bit_idx];
    end
  endgenerate

  // phase 0 requests the upper half, phase 1 the lower half
  assign fb_rd_en_o   = shifting_i && !phase_i[1];
  assign fb_rd_addr_o = {phase_i[0], row_i, col_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= 3'b000;
      rgb_q <= 6'b000000;
      clk_q <= 1'b0;
    end else begin
      if (shifting_i && phase_i == 2'd1) up_q  <= pick;
      if (shifting_i && phase_i == 2'd2) rgb_q <= {up_q, pick};
      clk_q <= shifting_i && (phase_i == 2'd3);
    end
  end

  assign pnl_clk_o = clk_q;
  assign pnl_rgb_o = rgb_q;

endmodule

// File: rtl/led_matrix_scan.sv
module led_matrix_scan
  import led_scan_pkg::*;
#(
  parameter int COLS       = 64,
  parameter int ROWS       = 32,
  parameter int MAX_PLANES = 8,
  parameter int CH_W       = 8,
  parameter int OE_UNIT    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  plane_cnt_i,
  output logic        fb_rd_en_o,
  output logic [11:0] fb_rd_addr_o,
  input  logic [23:0] fb_rd_data_i,
  output logic        pnl_clk_o,
  output logic        pnl_lat_o,
  output logic        pnl_oe_n_o,
  output logic [4:0]  pnl_row_o,
  output logic [5:0]  pnl_rgb_o
);

  localparam int COL_W  = $clog2(COLS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int PL_W   = $clog2(MAX_PLANES);
  localparam int DEP_W  = $clog2(MAX_PLANES + 1);
  localparam int ADDR_W = 1 + ROW_W + COL_W;
  localparam int TW     = $clog2(OE_UNIT * (2 ** (MAX_PLANES - 1)) + 1);

  scan_state_e      state;
  logic [1:0]       phase;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic [PL_W-1:0]  plane;
  logic [DEP_W-1:0] depth;
  logic             load_disp;
  logic [PL_W-1:0]  disp_plane;
  logic             disp_busy;
  logic             shifting;

  assign shifting = (state == SCAN_SHIFT);

  scan_sequencer #(
    .COLS(COLS), .ROWS(ROWS), .MAX_PLANES(MAX_PLANES),
    .COL_W(COL_W), .ROW_W(ROW_W), .PL_W(PL_W), .DEP_W(DEP_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .depth_req_i (DEP_W'(plane_cnt_i)),
    .disp_busy_i (disp_busy),
    .state_o     (state),
    .phase_o     (phase),
    .col_o       (col),
    .row_o       (row),
    .plane_o     (plane),
    .depth_o     (depth),
    .load_disp_o (load_disp),
    .disp_plane_o(disp_plane),
    .pnl_row_o   (pnl_row_o),
    .pnl_lat_o   (pnl_lat_o)
  );

  oe_weight_timer #(
    .OE_UNIT(OE_UNIT), .MAX_PLANES(MAX_PLANES), .PL_W(PL_W), .TW(TW)
  ) u_oe (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_disp),
    .plane_i(disp_plane),
    .busy_o (disp_busy),
    .oe_n_o (pnl_oe_n_o)
  );

  pixel_fetch #(
    .CH_W(CH_W), .COL_W(COL_W), .ROW_W(ROW_W), .PL_W(PL_W),
    .DEP_W(DEP_W), .ADDR_W(ADDR_W)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .shifting_i  (shifting),
    .phase_i     (phase),
    .col_i       (col),
    .row_i       (row),
    .plane_i     (plane),
    .depth_i     (depth),
    .fb_rd_en_o  (fb_rd_en_o),
    .fb_rd_addr_o(fb_rd_addr_o),
    .fb_rd_data_i(fb_rd_data_i),
    .pnl_clk_o   (pnl_clk_o),
    .pnl_rgb_o   (pnl_rgb_o)
  );

endmodule

// File: rtl/led_scan_checker.sv
module led_scan_checker #(
  parameter int ROW_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pnl_clk,
  input logic             pnl_lat,
  input logic             pnl_oe_n,
  input logic [ROW_W-1:0] pnl_row,
  input logic [5:0]       pnl_rgb,
  input logic             fb_rd_en
);

  logic seen_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_lat <= 1'b0;
    else if (pnl_lat) seen_lat <= 1'b1;
  end

  assert_lat_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pnl_lat |-> pnl_oe_n);

  assert_lat_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pnl_lat |=> !pnl_lat);

  assert_row_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pnl_oe_n && !$past(pnl_oe_n)) |-> $stable(pnl_row));

  assert_oe_after_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pnl_oe_n) |-> $past(pnl_lat));

  assert_data_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pnl_clk) |-> $stable(pnl_rgb));

  assert_clk_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pnl_clk |=> !pnl_clk);

  assert_no_read_at_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_en |-> !pnl_lat);

  assert_blank_until_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_lat |-> pnl_oe_n);

endmodule

bind led_matrix_scan led_scan_checker #(.ROW_W(ROW_W)) u_scan_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pnl_clk (pnl_clk_o),
  .pnl_lat (pnl_lat_o),
  .pnl_oe_n(pnl_oe_n_o),
  .pnl_row (pnl_row_o),
  .pnl_rgb (pnl_rgb_o),
  .fb_rd_en(fb_rd_en_o)
);

// File: tb/sim_led_matrix_scan.sv
module sim_led_matrix_scan;

  localparam int CLK_PERIOD = 10;
  localparam int COLS       = 64;
  localparam int ROWS       = 32;
  localparam int UNIT       = 2;
  localparam int LOAD_GAP   = 4 * COLS + 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  plane_cnt = 4'd3;
  logic        fb_rd_en;
  logic [11:0] fb_rd_addr;
  logic [23:0] fb_rd_data = '0;
  logic        pnl_clk, pnl_lat, pnl_oe_n;
  logic [4:0]  pnl_row;
  logic [5:0]  pnl_rgb;

  always #(CLK_PERIOD / 2) clk = ~clk;

  led_matrix_scan u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .plane_cnt_i (plane_cnt),
    .fb_rd_en_o  (fb_rd_en),
    .fb_rd_addr_o(fb_rd_addr),
    .fb_rd_data_i(fb_rd_data),
    .pnl_clk_o   (pnl_clk),
    .pnl_lat_o   (pnl_lat),
    .pnl_oe_n_o  (pnl_oe_n),
    .pnl_row_o   (pnl_row),
    .pnl_rgb_o   (pnl_rgb)
  );

  function automatic logic [23:0] pat(input int a);
    logic [31:0] x;
    logic [31:0] h;
    x = a;
    h = x * 32'h9E3779B1;
    h = h ^ (h >> 15);
    return h[27:4];
  endfunction

  function automatic int clampd(input int v);
    if (v < 1) return 1;
    if (v > 8) return 8;
    return v;
  endfunction

  // frame buffer model: one-cycle read latency
  always_ff @(posedge clk) begin
    if (fb_rd_en) fb_rd_data <= pat(int'(fb_rd_addr));
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model state
  int exp_row = 0, exp_plane = 0, exp_depth = 3, exp_col = 0;
  int disp_plane = 0, oe_len = 0;
  int since_lat = 0, since_clk = 0, rd_cnt = 0;
  int frame_idx = 0, lat_in_frame = 0, cycles = 0;
  bit latched_any = 0, first_clk = 0, clk_seen = 0, wd_fired = 0;
  logic       prev_clk = 0, prev_lat = 0, prev_oe_n = 1;
  logic [4:0] prev_row = '0;
  logic [5:0] prev_rgb = '0;
  int         bsel;
  logic [23:0] wu, wl;
  logic [5:0]  exp_rgb;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 190000 && !wd_fired) begin
      wd_fired = 1;
      chk(0, "watchdog total cycles", cycles, 190000);
    end
    if (rst_n) begin
      since_lat++;
      since_clk++;
      if (since_lat > 2000 && !wd_fired) begin
        wd_fired = 1;
        chk(0, "watchdog R5 scan stalled", since_lat, LOAD_GAP);
      end
      if (fb_rd_en) rd_cnt++;

      chk(!(pnl_lat && !pnl_oe_n), "R7 enable off while latching", pnl_oe_n, 1);
      if (!latched_any) chk(pnl_oe_n == 1'b1, "R10 blank before first latch", pnl_oe_n, 1);
      if (!pnl_oe_n && !prev_oe_n)
        chk(pnl_row == prev_row, "R7 row held while lit", pnl_row, prev_row);
      if (pnl_lat && prev_lat) chk(0, "R7 latch longer than one cycle", 2, 1);

      // shift clock rising edge
      if (pnl_clk && !prev_clk) begin
        chk(pnl_rgb == prev_rgb, "R1 data set before clock edge", pnl_rgb, prev_rgb);
        if (first_clk) chk(since_lat == 5, "R8 first clock after latch", since_lat, 5);
        else if (clk_seen) chk(since_clk == 4, "R1 shift clock period", since_clk, 4);
        chk(exp_col < COLS, "R1 too many clocks in row-load", exp_col, COLS - 1);
        bsel = 8 - exp_depth + exp_plane;
        wu = pat(exp_row * COLS + exp_col);
        wl = pat(ROWS * COLS + exp_row * COLS + exp_col);
        exp_rgb = {wu[16+bsel], wu[8+bsel], wu[bsel], wl[16+bsel], wl[8+bsel], wl[bsel]};
        chk(pnl_rgb == exp_rgb, "R2 R4 colour bits", pnl_rgb, exp_rgb);
        exp_col++;
        since_clk = 0;
        first_clk = 0;
        clk_seen = 1;
      end

      // latch pulse
      if (pnl_lat && !prev_lat) begin
        chk(exp_col == COLS, "R1 clocks per row-load", exp_col, COLS);
        if (latched_any) begin
          chk(rd_cnt == 2 * COLS, "R3 reads per row-load", rd_cnt, 2 * COLS);
          chk(since_lat == LOAD_GAP, "R11 latch spacing", since_lat, LOAD_GAP);
        end
        chk(pnl_row == exp_row, "R5 row address at latch", pnl_row, exp_row);
        disp_plane = exp_plane;
        lat_in_frame++;
        if (exp_plane == exp_depth - 1) begin
          exp_plane = 0;
          if (exp_row == ROWS - 1) begin
            exp_row = 0;
            chk(lat_in_frame == ROWS * exp_depth, "R9 latches per frame",
                lat_in_frame, ROWS * exp_depth);
            frame_idx++;
            lat_in_frame = 0;
            exp_depth = clampd(int'(plane_cnt));
          end else begin
            exp_row++;
          end
        end else begin
          exp_plane++;
        end
        exp_col = 0;
        since_lat = 0;
        rd_cnt = 0;
        first_clk = 1;
        latched_any = 1;
      end

      // output-enable weighting
      if (!pnl_oe_n && prev_oe_n) begin
        chk(since_lat == 1, "R6 enable starts after latch", since_lat, 1);
        oe_len = 0;
      end
      if (!pnl_oe_n) oe_len++;
      if (pnl_oe_n && !prev_oe_n)
        chk(oe_len == (UNIT << disp_plane), "R6 lit time weight", oe_len, UNIT << disp_plane);
    end
    prev_clk  = pnl_clk;
    prev_lat  = pnl_lat;
    prev_oe_n = pnl_oe_n;
    prev_row  = pnl_row;
    prev_rgb  = pnl_rgb;
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(pnl_oe_n == 1'b1, "R10 enable off in reset", pnl_oe_n, 1);
      chk(pnl_lat == 1'b0, "R10 latch low in reset", pnl_lat, 0);
      chk(pnl_clk == 1'b0, "R10 clock low in reset", pnl_clk, 0);
    end
    #1 rst_n = 1'b1;
    // depth 3 first frame; change mid-frame to 0 (treated as 1)
    wait ((frame_idx == 0 && lat_in_frame >= 40) || wd_fired);
    @(negedge clk);
    #1 plane_cnt = 4'd0;
    // change mid-frame to 12 (treated as 8)
    wait ((frame_idx == 2 && lat_in_frame >= 10) || wd_fired);
    @(negedge clk);
    #1 plane_cnt = 4'd12;
    wait (frame_idx >= 4 || wd_fired);
    repeat (20) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule